// File: doc/BRIEF.md
# Nibble-RAM Bank Controller

This block sits between a CPU with a 16-bit address bus and a cartridge ROM of up to sixteen 16 KiB banks. It owns two control registers and a 512-entry by 4-bit RAM. CPU writes into the lower control area (0x0000-0x3FFF) load one of the two registers. Address bit 8 chooses which: bit 8 clear reaches the RAM gate, bit 8 set reaches the ROM bank number. The block turns every CPU address in the ROM space into an 18-bit ROM array address. The upper 16 KiB window follows the selected bank.

The nibble RAM answers the whole external RAM window (0xA000-0xBFFF). Only the low nine address bits index it, so the 512 entries repeat every 512 bytes. Only the low four data bits are stored. Reads return the stored nibble under an upper nibble of ones. While the RAM gate is closed, reads give 0xFF and writes are dropped. The ROM array itself is outside the block.

Top module: `nibble_bank_ctrl`

## Requirements
- R1: After reset the RAM gate is closed and the ROM bank number is 1.
- R2: A write with address in 0x0000-0x3FFF and address bit 8 clear opens the RAM gate when the full data byte is 0x0A. Any other byte closes it. The gate changes at that clock edge.
- R3: A write with address in 0x0000-0x3FFF and address bit 8 set loads data bits 3:0 as the bank number. The value 0 is stored as 1.
- R4: Writes to addresses at or above 0x4000 change neither the gate nor the bank number.
- R5: For CPU addresses 0x0000-0x3FFF, rom_addr equals {4'b0000, cpu_addr[13:0]}. rom_addr is combinational.
- R6: For CPU addresses 0x4000-0x7FFF, rom_addr equals {bank[3:0], cpu_addr[13:0]}.
- R7: A write while the gate is open, to any address in 0xA000-0xBFFF, stores cpu_wdata[3:0] in entry cpu_addr[8:0]. Entries are therefore mirrored every 512 bytes.
- R8: A read (cpu_rd high) in 0xA000-0xBFFF while the gate is open returns {4'hF, entry cpu_addr[8:0]} in the same cycle.
- R9: While the gate is closed, reads in 0xA000-0xBFFF return 0xFF and writes there leave the RAM unchanged.
- R10: cpu_rdata is 0xFF whenever cpu_rd is low or the address lies outside 0xA000-0xBFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one write per cycle held high |
| cpu_rd | input | 1 | Read strobe |
| cpu_rdata | output | 8 | Read data from the nibble RAM, 0xFF when not served |
| rom_addr | output | 18 | ROM array address for the current CPU address |

## Verification
Directed control writes cover several patterns. Bank values 0, 5, 0xF and bytes with set upper bits show whether zero is remapped and whether the upper data bits are masked. Bytes 0x0A, 0x1A and 0x00 on the gate show whether the comparison uses the full byte or only the low nibble. Writes through mirror addresses such as 0xB205, read back at 0xA005, show that only the low nine address bits index the RAM. A long random mix of control, ROM-window, RAM-window and unmapped accesses runs against a behavioural model to catch ordering faults. These are reads in the same cycle as writes and gate changes between accesses.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

   typedef enum logic [1:0] {
      RGN_CTRL  = 2'd0,
      RGN_ROMHI = 2'd1,
      RGN_RAM   = 2'd2,
      RGN_NONE  = 2'd3
   } region_t;

   // classify a CPU access from its three top address bits
   function automatic region_t classify(input logic [2:0] top3, input logic [2:0] ram_tag);
      region_t r;
      if (top3[2:1] == 2'b00)       r = RGN_CTRL;
      else if (top3[2:1] == 2'b01)  r = RGN_ROMHI;
      else if (top3 == ram_tag)     r = RGN_RAM;
      else                          r = RGN_NONE;
      return r;
   endfunction

endpackage

// File: rtl/nbc_decode.sv
module nbc_decode
   import nbc_pkg::*;
#(
   parameter logic [2:0] RAM_TAG = 3'b101
) (
   input  logic [2:0] addr_top,
   input  logic       addr_sel,
   input  logic       wr,
   input  logic       rd,
   output logic       ctrl_wr,
   output logic       ctrl_is_bank,
   output logic       ram_hit_wr,
   output logic       ram_hit_rd
);
   region_t rgn;

   always_comb begin
      rgn          = classify(addr_top, RAM_TAG);
      ctrl_wr      = wr && (rgn == RGN_CTRL);
      ctrl_is_bank = addr_sel;
      ram_hit_wr   = wr && (rgn == RGN_RAM);
      ram_hit_rd   = rd && (rgn == RGN_RAM);
   end
endmodule

// File: rtl/nbc_ctrl_regs.sv
module nbc_ctrl_regs #(
   parameter int              DATA_W     = 8,
   parameter int              BANK_W     = 4,
   parameter logic [7:0]      ENABLE_KEY = 8'h0A,
   parameter int              BANK_RESET = 1,
   parameter bit              ZERO_REMAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic              is_bank,
   input  logic [DATA_W-1:0] wdata,
   output logic              ram_en,
   output logic [BANK_W-1:0] bank
);
   localparam logic [BANK_W-1:0] BANK_INIT = BANK_W'(BANK_RESET);
   localparam logic [BANK_W-1:0] BANK_ONE  = BANK_W'(1);

   logic [BANK_W-1:0] bank_raw;
   logic [BANK_W-1:0] bank_nxt;
   logic              key_match;

   assign bank_raw  = wdata[BANK_W-1:0];
   assign key_match = (wdata == DATA_W'(ENABLE_KEY));

   generate
      if (ZERO_REMAP) begin : g_remap
         assign bank_nxt = (bank_raw == '0) ? BANK_ONE : bank_raw;
      end else begin : g_direct
         assign bank_nxt = bank_raw;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ram_en <= 1'b0;
         bank   <= BANK_INIT;
      end else if (ctrl_wr) begin
         if (is_bank) bank   <= bank_nxt;
         else         ram_en <= key_match;
      end
   end
endmodule

// File: rtl/nbc_nibble_ram.sv
module nbc_nibble_ram #(
   parameter int AW = 9,
   parameter int DW = 4
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/nbc_rom_map.sv
module nbc_rom_map #(
   parameter int WIN_W  = 14,
   parameter int BANK_W = 4
) (
   input  logic                    hi_win,
   input  logic [WIN_W-1:0]        offset,
   input  logic [BANK_W-1:0]       bank,
   output logic [BANK_W+WIN_W-1:0] rom_addr
);
   always_comb begin
      rom_addr = {(hi_win ? bank : {BANK_W{1'b0}}), offset};
   end
endmodule

// File: rtl/nibble_bank_ctrl.sv
module nibble_bank_ctrl #(
   parameter int         ADDR_W     = 16,
   parameter int         DATA_W     = 8,
   parameter int         BANK_W     = 4,
   parameter int         WIN_W      = 14,
   parameter int         RAM_AW     = 9,
   parameter int         RAM_DW     = 4,
   parameter int         SEL_BIT    = 8,
   parameter logic [7:0] ENABLE_KEY = 8'h0A,
   parameter bit         ZERO_REMAP = 1'b1,
   parameter logic [2:0] RAM_TAG    = 3'b101,
   parameter int         ROM_AW     = BANK_W + WIN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [ROM_AW-1:0] rom_addr
);
   localparam int FILL_W = DATA_W - RAM_DW;

   // elaboration-time parameter checks
   generate
      if (ADDR_W != 16) begin : g_bad_addr
         $error("nibble_bank_ctrl: address bus must be 16 bits");
      end
      if (WIN_W != ADDR_W - 2) begin : g_bad_win
         $error("nibble_bank_ctrl: window must cover one quarter of the space");
      end
      if (RAM_AW > ADDR_W - 3 || SEL_BIT >= WIN_W) begin : g_bad_ram
         $error("nibble_bank_ctrl: RAM index or select bit out of range");
      end
      if (RAM_DW >= DATA_W || ROM_AW != BANK_W + WIN_W) begin : g_bad_w
         $error("nibble_bank_ctrl: inconsistent data or ROM width");
      end
   endgenerate

   logic              ctrl_wr, ctrl_is_bank, ram_hit_wr, ram_hit_rd;
   logic              ram_en;
   logic [BANK_W-1:0] rom_bank;
   logic [RAM_DW-1:0] ram_q;

   nbc_decode #(.RAM_TAG(RAM_TAG)) u_dec (
      .addr_top     (cpu_addr[ADDR_W-1:ADDR_W-3]),
      .addr_sel     (cpu_addr[SEL_BIT]),
      .wr           (cpu_wr),
      .rd           (cpu_rd),
      .ctrl_wr      (ctrl_wr),
      .ctrl_is_bank (ctrl_is_bank),
      .ram_hit_wr   (ram_hit_wr),
      .ram_hit_rd   (ram_hit_rd)
   );

   nbc_ctrl_regs #(
      .DATA_W     (DATA_W),
      .BANK_W     (BANK_W),
      .ENABLE_KEY (ENABLE_KEY),
      .BANK_RESET (1),
      .ZERO_REMAP (ZERO_REMAP)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_wr (ctrl_wr),
      .is_bank (ctrl_is_bank),
      .wdata   (cpu_wdata),
      .ram_en  (ram_en),
      .bank    (rom_bank)
   );

   nbc_nibble_ram #(.AW(RAM_AW), .DW(RAM_DW)) u_ram (
      .clk   (clk),
      .we    (ram_hit_wr && ram_en),
      .addr  (cpu_addr[RAM_AW-1:0]),
      .wdata (cpu_wdata[RAM_DW-1:0]),
      .rdata (ram_q)
   );

   nbc_rom_map #(.WIN_W(WIN_W), .BANK_W(BANK_W)) u_map (
      .hi_win   (cpu_addr[WIN_W]),
      .offset   (cpu_addr[WIN_W-1:0]),
      .bank     (rom_bank),
      .rom_addr (rom_addr)
   );

   always_comb begin
      if (ram_hit_rd && ram_en) cpu_rdata = {{FILL_W{1'b1}}, ram_q};
      else                      cpu_rdata = {DATA_W{1'b1}};
   end
endmodule

// File: rtl/nbc_checker.sv
module nbc_checker (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] cpu_addr,
   input logic [7:0]  cpu_wdata,
   input logic        cpu_wr,
   input logic        cpu_rd,
   input logic [7:0]  cpu_rdata,
   input logic [17:0] rom_addr,
   input logic        ram_en,
   input logic [3:0]  bank
);
   logic ctl_area, ram_area;
   assign ctl_area = (cpu_addr[15:14] == 2'b00);
   assign ram_area = (cpu_addr[15:13] == 3'b101);

   a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wr && ctl_area && !cpu_addr[8] && cpu_wdata == 8'h0A |=> ram_en);

   a_r2_other_closes: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wr && ctl_area && !cpu_addr[8] && cpu_wdata != 8'h0A |=> !ram_en);

   a_r3_bank_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bank != 4'h0);

   a_r4_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_wr && ctl_area) |=> $stable(bank) && $stable(ram_en));

   a_r5_low_window: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_addr[15:14] == 2'b00 |-> rom_addr == {4'h0, cpu_addr[13:0]});

   a_r6_high_window: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_addr[15:14] == 2'b01 |-> rom_addr == {bank, cpu_addr[13:0]});

   a_r8_fill_nibble: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd && ram_area |-> cpu_rdata[7:4] == 4'hF);

   a_r9_closed_read: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd && ram_area && !ram_en |-> cpu_rdata == 8'hFF);

   a_r10_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_rd && ram_area) |-> cpu_rdata == 8'hFF);
endmodule

bind nibble_bank_ctrl nbc_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_addr  (cpu_addr),
   .cpu_wdata (cpu_wdata),
   .cpu_wr    (cpu_wr),
   .cpu_rd    (cpu_rd),
   .cpu_rdata (cpu_rdata),
   .rom_addr  (rom_addr),
   .ram_en    (ram_en),
   .bank      (rom_bank)
);

// File: tb/sim_nibble_bank_ctrl.sv
module sim_nibble_bank_ctrl;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_wr = 1'b0;
   logic        cpu_rd = 1'b0;
   logic [7:0]  cpu_rdata;
   logic [17:0] rom_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model state
   bit       m_en;
   int       m_bank;
   bit [3:0] m_mem [512];

   nibble_bank_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .rom_addr(rom_addr)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   // one bus cycle: drive at falling edge, compare, then advance the model
   task automatic step(input logic [15:0] a, input logic [7:0] d,
                       input bit w, input bit r, input string tag);
      logic [17:0] e_rom;
      logic [7:0]  e_rd;
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = w; cpu_rd = r;
      #1;
      if (a[15] == 1'b0) begin
         e_rom = a[14] ? {4'(m_bank), a[13:0]} : {4'h0, a[13:0]};
         checks++;
         if (rom_addr !== e_rom) begin
            errors++;
            $display("FAIL %s rom_addr addr=%h got %h exp %h", tag, a, rom_addr, e_rom);
         end
      end
      if (r && a[15:13] == 3'b101 && m_en) e_rd = {4'hF, m_mem[a[8:0]]};
      else                                 e_rd = 8'hFF;
      checks++;
      if (cpu_rdata !== e_rd) begin
         errors++;
         $display("FAIL %s cpu_rdata addr=%h got %h exp %h", tag, a, cpu_rdata, e_rd);
      end
      @(posedge clk);
      if (w) begin
         if (a[15:14] == 2'b00) begin
            if (a[8]) m_bank = (d[3:0] == 4'h0) ? 1 : int'(d[3:0]);
            else      m_en   = (d == 8'h0A);
         end else if (a[15:13] == 3'b101 && m_en) begin
            m_mem[a[8:0]] = d[3:0];
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      m_en = 1'b0; m_bank = 1;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      step(16'h4123, 8'h00, 0, 0, "R1");
      step(16'hA000, 8'h00, 0, 1, "R1");
      // R5: low window
      step(16'h0000, 8'h00, 0, 0, "R5");
      step(16'h3FFF, 8'h00, 0, 0, "R5");
      // R3 and R6: bank loads, masking and zero remap
      step(16'h2100, 8'h03, 1, 0, "R3");
      step(16'h7FFF, 8'h00, 0, 0, "R6");
      step(16'h0100, 8'hE5, 1, 0, "R3");
      step(16'h5A5A, 8'h00, 0, 0, "R6");
      step(16'h3F00, 8'h00, 1, 0, "R3");
      step(16'h4000, 8'h00, 0, 0, "R3");
      step(16'h0100, 8'hF0, 1, 0, "R3");
      step(16'h6001, 8'h00, 0, 0, "R3");
      step(16'h1F1F, 8'h0F, 1, 0, "R3");
      step(16'h7ABC, 8'h00, 0, 0, "R6");
      // R4: writes above the control area leave registers alone
      step(16'h4100, 8'h02, 1, 0, "R4");
      step(16'h6000, 8'h00, 1, 0, "R4");
      step(16'h8100, 8'h0A, 1, 0, "R4");
      step(16'hC000, 8'h0A, 1, 0, "R4");
      step(16'h4000, 8'h00, 0, 0, "R4");
      step(16'hA010, 8'h00, 0, 1, "R4");
      // R2: open the gate and fill the RAM
      step(16'h0000, 8'h0A, 1, 0, "R2");
      for (int i = 0; i < 512; i++)
         step(16'hA000 + 16'(i), 8'(i * 7 + 3), 1, 0, "R7");
      step(16'hA1FF, 8'h00, 0, 1, "R8");
      // R7: mirrored write and read back
      step(16'hB205, 8'h7C, 1, 0, "R7");
      step(16'hA005, 8'h00, 0, 1, "R7");
      step(16'hBFFF, 8'h00, 0, 1, "R8");
      // R2 and R9: full-byte key, closed gate
      step(16'h0200, 8'h1A, 1, 0, "R2");
      step(16'hA005, 8'h00, 0, 1, "R9");
      step(16'hA005, 8'h03, 1, 0, "R9");
      step(16'h3E00, 8'h0A, 1, 0, "R2");
      step(16'hA005, 8'h00, 0, 1, "R9");
      step(16'h0000, 8'h00, 1, 0, "R2");
      step(16'hB000, 8'h00, 0, 1, "R9");
      step(16'h00FF, 8'h0A, 1, 0, "R2");
      // R10: idle or out-of-window reads
      step(16'hA005, 8'h00, 0, 0, "R10");
      step(16'hC005, 8'h00, 0, 1, "R10");
      step(16'h4005, 8'h00, 0, 1, "R10");

      // mixed random traffic
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] a;
         logic [7:0]  d;
         int kind;
         kind = int'($urandom % 4);
         d = 8'($urandom);
         case (kind)
            0: begin
               a = {2'b00, 14'($urandom)};
               if (!a[8] && ($urandom % 3 != 0)) d = 8'h0A;
            end
            1: a = {2'b01, 14'($urandom)};
            2: a = {3'b101, 13'($urandom)};
            default: a = {3'b100 + 3'($urandom % 2) * 3'd2, 13'($urandom)};
         endcase
         step(a, d, bit'($urandom % 2), bit'($urandom % 2), "R8");
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule